// File: doc/BRIEF.md
# I2C Slave Register Interface

This block is the bus-facing front end of a small sensor with four 16-bit registers. It receives SCL and SDA samples that are already synchronised to the system clock. It drives a single open-drain enable for SDA, and it never drives SCL. The device answers at one of eight 7-bit addresses. A 3-bit strap input adds its value to a base address to select which one. A transfer first writes a 2-bit pointer. Data words then move high byte first.

On the register side the block presents the current pointer, a read-data input, and a write word with a one-cycle write strobe. It also gives a one-cycle read strobe at the end of every byte the slave sends, so that neighbouring logic such as an alert latch can react to bus reads. Several special bus cases are handled:
- a general call;
- the start byte (address zero with the read bit set);
- high-speed master codes, which are not acknowledged and raise a flag until STOP;
- an SCL-low timeout, which drops the transfer and frees SDA.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal ADDR_BASE (default 0x44) plus the strap value. It does so for either direction bit. Any other address that is not a special code is left unacknowledged: SDA stays released through the ninth clock.
- R2: In a write transfer, the byte after the address sets the pointer to its bits 1:0. Each following pair of bytes produces one write strobe carrying {first byte, second byte} at that pointer. Further pairs keep writing the same register.
- R3: When the pointer is 0 (the read-only temperature register), data bytes are still acknowledged, but no write strobe is produced.
- R4: A read transfer returns the register at the most recently written pointer, high byte first. The pointer persists across transfers. One read strobe pulses after each byte sent.
- R5: A master NACK after a sent byte ends the transmission. The slave then drives no further bits until the next START.
- R6: General call (byte 0x00) is acknowledged, and its second byte is acknowledged and discarded. A third byte gets no acknowledge. No write strobe occurs and the pointer is unchanged.
- R7: The start byte (0x01) is acknowledged and is followed by the high and low bytes of the register at the pointer. After reset the pointer is 0.
- R8: A first byte of the form 00001xxx is not acknowledged and sets the high-speed flag. The flag stays set across repeated STARTs and clears on the next STOP.
- R9: If SCL stays low for TIMEOUT_CYC clocks during an active transfer, the slave releases SDA and ignores the bus until a new START.
- R10: SDA is changed by the slave only while SCL is low. It therefore holds steady across every SCL high phase, and the acknowledge is held low for the whole ninth clock.
- R11: A repeated START in the middle of a write abandons any half-received data word and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| addr_sel_i | input | 3 | Strap value added to the base address |
| rd_data_i | input | 16 | Contents of the register at the pointer |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_idx_o | output | 2 | Register pointer |
| wr_data_o | output | 16 | Word to be written |
| wr_en_o | output | 1 | One-cycle write strobe |
| rd_strobe_o | output | 1 | One-cycle pulse after each sent byte |
| hs_mode_o | output | 1 | High-speed code seen, cleared by STOP |

## Verification
The bench sweeps every strap value against sixteen neighbouring addresses. A decoder with the wrong base, or one that ignores the strap, would acknowledge a neighbour or miss its own address. It writes and reads back all four registers. A design that let the temperature register be written would raise a write strobe, and one that swapped byte order would return the halves reversed. It drives the special cases the bench targets, each of which has its own failure:

- **General call.** A design that forwarded the discarded byte would change the pointer or write.
- **High-speed code.** A design that acknowledged it, or cleared the flag on a repeated START, would be caught.
- **Repeated START mid-word.** A design that kept the half-received byte would produce a stray write.
- **SCL-low timeout.** A design with no timeout would keep pulling SDA low.

// File: rtl/i2c_slv_pkg.sv
// Shared types and constants for the I2C slave register interface.
package i2c_slv_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int IDX_W  = 2;
    localparam int ADDR_W = 7;
    localparam int BITCNT_W = 4;

    // High-speed master code prefix: first byte 00001xxx
    localparam logic [4:0] HS_PREFIX = 5'b00001;
    localparam logic [BYTE_W-1:0] GCALL_BYTE = 8'h00;
    localparam logic [BYTE_W-1:0] SBYTE_BYTE = 8'h01;

    // Bit-level engine state
    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring bus until START
        ST_RX,     // shifting in a byte
        ST_ACKW,   // byte received, waiting for SCL low to drive ack
        ST_ACK,    // ninth clock of a received byte
        ST_TX,     // shifting out a byte
        ST_TACK,   // waiting for master ack bit
        ST_TLOAD   // master acked, load next byte on SCL fall
    } slv_state_e;

    // Meaning of the byte currently being moved
    typedef enum logic [2:0] {
        PH_ADDR, PH_INDEX, PH_MSB, PH_LSB, PH_GC2, PH_GCX, PH_RDMSB, PH_RDLSB
    } slv_phase_e;
endpackage

// File: rtl/i2c_bus_events.sv
// Detects SCL edges and START/STOP conditions from synchronised samples.
// Assumes scl_i/sda_i are already synchronised to clk; one cycle of history.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Hold previous line levels; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_scl_timeout.sv
// Counts clocks of SCL low while a transfer is active and flags expiry.
// Assumes LIMIT >= 1; the counter saturates at LIMIT.
module i2c_scl_timeout #(
    parameter int LIMIT = 1_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic scl_i,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Run while engaged with SCL low, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || scl_i) cnt <= '0;
        else if (cnt != LIM)            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);
endmodule

// File: rtl/i2c_slave_core.sv
// Byte engine: address decode, ack generation, pointer, word assembly and
// byte transmission. Assumes one-cycle event pulses from i2c_bus_events and
// a combinational register file answering rd_data_i for reg_idx_o.
module i2c_slave_core
    import i2c_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              timeout,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              busy,
    output logic              sda_oe,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_en,
    output logic              rd_strobe,
    output logic              hs_mode
);
    slv_state_e            state;
    slv_phase_e            phase, phase_d;
    logic [BITCNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]     shreg, hi_q;
    logic [BYTE_W-1:0]     rx_byte;
    logic [IDX_W-1:0]      idx_q;
    logic [WORD_W-1:0]     wdata_q;
    logic                  ack_q, ack_d, oe_q, wr_q, stb_q, hs_q;
    logic                  idx_ld, hi_ld, word_done, hs_set;

    assign rx_byte = {shreg[BYTE_W-2:0], sda_i};

    // Decide ack and next phase for a completed received byte.
    always_comb begin
        ack_d = 1'b0; phase_d = phase;
        idx_ld = 1'b0; hi_ld = 1'b0; word_done = 1'b0; hs_set = 1'b0;
        case (phase)
            PH_ADDR: begin
                if (rx_byte[7:3] == HS_PREFIX) hs_set = 1'b1;
                else if (rx_byte == GCALL_BYTE) begin ack_d = 1'b1; phase_d = PH_GC2; end
                else if (rx_byte == SBYTE_BYTE) begin ack_d = 1'b1; phase_d = PH_RDMSB; end
                else if (rx_byte[7:1] == dev_addr) begin
                    ack_d = 1'b1;
                    phase_d = rx_byte[0] ? PH_RDMSB : PH_INDEX;
                end
            end
            PH_INDEX: begin ack_d = 1'b1; phase_d = PH_MSB; idx_ld = 1'b1; end
            PH_MSB:   begin ack_d = 1'b1; phase_d = PH_LSB; hi_ld = 1'b1; end
            PH_LSB:   begin ack_d = 1'b1; phase_d = PH_MSB; word_done = 1'b1; end
            PH_GC2:   begin ack_d = 1'b1; phase_d = PH_GCX; end
            default:  ack_d = 1'b0;
        endcase
    end

    // Bus engine: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; phase <= PH_ADDR; bit_cnt <= '0; shreg <= '0;
            hi_q <= '0; idx_q <= '0; wdata_q <= '0; ack_q <= 1'b0;
            oe_q <= 1'b0; wr_q <= 1'b0; stb_q <= 1'b0; hs_q <= 1'b0;
        end else begin
            wr_q  <= 1'b0;
            stb_q <= 1'b0;
            if (start_det) begin
                state <= ST_RX; phase <= PH_ADDR; bit_cnt <= '0; oe_q <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE; oe_q <= 1'b0; hs_q <= 1'b0;
            end else if (timeout) begin
                state <= ST_IDLE; oe_q <= 1'b0;
            end else begin
                case (state)
                    ST_RX: if (scl_rise) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BITCNT_W'(BYTE_W - 1)) begin
                            state <= ST_ACKW;
                            ack_q <= ack_d;
                            phase <= phase_d;
                            if (hs_set) hs_q <= 1'b1;
                            if (idx_ld) idx_q <= rx_byte[IDX_W-1:0];
                            if (hi_ld)  hi_q <= rx_byte;
                            if (word_done) begin
                                wdata_q <= {hi_q, rx_byte};
                                wr_q    <= (idx_q != '0);
                            end
                        end
                    end
                    ST_ACKW: if (scl_fall) begin
                        oe_q  <= ack_q;
                        state <= ack_q ? ST_ACK : ST_IDLE;
                    end
                    ST_ACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (phase == PH_RDMSB) begin
                            shreg <= {rd_data_i[WORD_W-2:BYTE_W], 1'b0};
                            oe_q  <= ~rd_data_i[WORD_W-1];
                            state <= ST_TX;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        else if (scl_fall) begin
                            if (bit_cnt == BITCNT_W'(BYTE_W)) begin
                                oe_q  <= 1'b0;
                                stb_q <= 1'b1;
                                state <= ST_TACK;
                            end else begin
                                oe_q  <= ~shreg[BYTE_W-1];
                                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_TACK: if (scl_rise) begin
                        if (!sda_i && phase == PH_RDMSB) begin
                            phase <= PH_RDLSB;
                            state <= ST_TLOAD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_TLOAD: if (scl_fall) begin
                        shreg   <= {rd_data_i[BYTE_W-2:0], 1'b0};
                        oe_q    <= ~rd_data_i[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= ST_TX;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy      = (state != ST_IDLE);
    assign sda_oe    = oe_q;
    assign reg_idx   = idx_q;
    assign wr_data   = wdata_q;
    assign wr_en     = wr_q;
    assign rd_strobe = stb_q;
    assign hs_mode   = hs_q;
endmodule

// File: rtl/i2c_reg_slave.sv
// Top: I2C slave front end for a four-register sensor.
// Assumes synchronised SCL/SDA inputs and an external open-drain SDA pad.
module i2c_reg_slave #(
    parameter logic [6:0] ADDR_BASE   = 7'h44,
    parameter int         TIMEOUT_CYC = 1_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [2:0]  addr_sel_i,
    input  logic [15:0] rd_data_i,
    output logic        sda_oe_o,
    output logic [1:0]  reg_idx_o,
    output logic [15:0] wr_data_o,
    output logic        wr_en_o,
    output logic        rd_strobe_o,
    output logic        hs_mode_o
);
    logic scl_rise, scl_fall, start_det, stop_det, busy, expired;
    logic [6:0] dev_addr;

    assign dev_addr = ADDR_BASE + 7'(addr_sel_i);

    i2c_bus_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_scl_timeout #(.LIMIT(TIMEOUT_CYC)) u_to (
        .clk(clk), .rst_n(rst_n), .active(busy), .scl_i(scl_i), .expired(expired)
    );

    i2c_slave_core u_core (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .timeout(expired),
        .sda_i(sda_i), .dev_addr(dev_addr), .rd_data_i(rd_data_i),
        .busy(busy), .sda_oe(sda_oe_o), .reg_idx(reg_idx_o),
        .wr_data(wr_data_o), .wr_en(wr_en_o), .rd_strobe(rd_strobe_o),
        .hs_mode(hs_mode_o)
    );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
// Protocol checker for i2c_reg_slave, attached by bind.
module i2c_reg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_oe_o,
    input logic       wr_en_o,
    input logic       rd_strobe_o,
    input logic       hs_mode_o,
    input logic [1:0] reg_idx_o
);
    // R10: slave changes SDA only after SCL was seen low
    p_sda_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_i));

    // R3: the read-only register is never written
    p_no_temp_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> reg_idx_o != 2'd0);

    // R4: read strobe is a single-cycle pulse
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_o |=> !rd_strobe_o);

    // R8: high-speed flag only drops on a STOP (SCL and SDA high)
    p_hs_clear_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode_o) |-> ($past(scl_i) && $past(sda_i)));

    // R2: a write strobe never coincides with a transmit strobe
    p_wr_rd_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_strobe_o));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe_o(sda_oe_o), .wr_en_o(wr_en_o), .rd_strobe_o(rd_strobe_o),
    .hs_mode_o(hs_mode_o), .reg_idx_o(reg_idx_o)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
    localparam int TO_CYC = 200;
    localparam logic [15:0] TEMP_VAL = 16'hF380;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] sel = 3'd0;
    logic sda_oe, wr_en, rd_stb, hs;
    logic [1:0] idx;
    logic [15:0] wdata, rdata;
    logic [15:0] regs [4];
    wire sda_line = sda_m & ~sda_oe;

    assign rdata = (idx == 2'd0) ? TEMP_VAL : regs[idx];

    i2c_reg_slave #(.ADDR_BASE(7'h44), .TIMEOUT_CYC(TO_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(sel), .rd_data_i(rdata), .sda_oe_o(sda_oe),
        .reg_idx_o(idx), .wr_data_o(wdata), .wr_en_o(wr_en),
        .rd_strobe_o(rd_stb), .hs_mode_o(hs)
    );

    int checks = 0, failures = 0, wr_cnt = 0, stb_cnt = 0, unstable = 0;
    logic [15:0] last_wdata = '0;
    logic [1:0]  last_widx = '0;
    logic [15:0] shadow [4];

    // Model register file and strobe counters.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) regs[i] <= '0;
        end else begin
            if (wr_en) begin
                wr_cnt <= wr_cnt + 1; last_wdata <= wdata; last_widx <= idx;
                regs[idx] <= wdata;
            end
            if (rd_stb) stb_cnt <= stb_cnt + 1;
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic half(); repeat (4) @(negedge clk); endtask
    task automatic do_start(); sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half(); endtask
    task automatic do_stop(); sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half(); endtask

    task automatic clk_bit(input logic b, output logic seen);
        logic pre;
        sda_m = b; half();
        pre = sda_line; scl_m = 1; half();
        seen = sda_line;
        if (pre !== seen) unstable++;
        scl_m = 0; half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(~mack, s);
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'h3C5A ^ (16'h1248 * 16'(i));
    endfunction

    logic [6:0] my_addr;
    logic a0, a1, a2, a3, a4;
    logic [7:0] hb, lb;
    int w0, s0;

    task automatic read_word(input logic [7:0] first, output logic acked,
                             output logic [15:0] word);
        logic [7:0] h, l;
        do_start(); send_byte(first, acked);
        recv_byte(1'b1, h); recv_byte(1'b0, l); do_stop();
        word = {h, l};
    endtask

    initial begin
        logic [15:0] word;
        shadow[0] = TEMP_VAL;
        for (int i = 1; i < 4; i++) shadow[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        half();
        chk(sda_oe == 0 && wr_en == 0 && rd_stb == 0 && hs == 0, "R1", "reset outputs quiet",
            {sda_oe, wr_en, rd_stb, hs}, 0);
        chk(idx == 0, "R7", "pointer after reset", idx, 0);

        // R7: start byte after reset returns temperature
        s0 = stb_cnt;
        read_word(8'h01, a0, word);
        chk(a0, "R7", "start byte ack", a0, 1);
        chk(word == TEMP_VAL, "R7", "start byte data", word, TEMP_VAL);
        chk(stb_cnt - s0 == 2, "R4", "two read strobes", stb_cnt - s0, 2);

        // R1: strap sweep against addresses 0x40..0x4F
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            for (int a = 8'h40; a < 8'h50; a++) begin
                do_start(); send_byte({7'(a), 1'b0}, a0); do_stop();
                chk(a0 == (a == 8'h44 + s), "R1", $sformatf("ack sel=%0d addr", s), a, 8'h44 + s);
            end
        end
        sel = 3'd5;
        my_addr = 7'h44 + 7'd5;

        // R2/R3/R4: write every register, then read back
        for (int i = 0; i < 4; i++) begin
            w0 = wr_cnt;
            do_start(); send_byte({my_addr, 1'b0}, a0); send_byte(8'(i), a1);
            chk(idx == 2'(i), "R2", "pointer loaded", idx, i);
            send_byte(pat(i)[15:8], a2); send_byte(pat(i)[7:0], a3); do_stop();
            chk(a0 && a1 && a2 && a3, "R2", "write bytes acked", {a0, a1, a2, a3}, 4'hF);
            if (i == 0) begin
                chk(wr_cnt == w0, "R3", "no write to reg 0", wr_cnt - w0, 0);
            end else begin
                chk(wr_cnt == w0 + 1 && last_wdata == pat(i) && last_widx == 2'(i),
                    "R2", "write word", last_wdata, pat(i));
                shadow[i] = pat(i);
            end
            s0 = stb_cnt;
            read_word({my_addr, 1'b1}, a0, word);
            chk(a0 && word == shadow[i], "R4", $sformatf("read back reg %0d", i), word, shadow[i]);
            chk(stb_cnt - s0 == 2, "R4", "strobes per read", stb_cnt - s0, 2);
            read_word({my_addr, 1'b1}, a0, word);
            chk(word == shadow[i], "R4", "pointer persists", word, shadow[i]);
        end

        // R2: two words in one transfer to reg 3
        w0 = wr_cnt;
        do_start(); send_byte({my_addr, 1'b0}, a0); send_byte(8'd3, a1);
        send_byte(8'h80, a2); send_byte(8'h01, a3); send_byte(8'h7F, a4); send_byte(8'hFE, a4);
        do_stop();
        shadow[3] = 16'h7FFE;
        chk(wr_cnt == w0 + 2 && last_wdata == 16'h7FFE, "R2", "second word", last_wdata, 16'h7FFE);

        // R6: general call
        w0 = wr_cnt;
        do_start(); send_byte(8'h00, a0); send_byte(8'h02, a1); send_byte(8'h33, a2); do_stop();
        chk(a0 && a1 && !a2, "R6", "gc ack pattern", {a0, a1, a2}, 3'b110);
        chk(wr_cnt == w0 && idx == 2'd3, "R6", "gc leaves pointer", idx, 3);
        read_word(8'h01, a0, word);
        chk(word == shadow[3], "R7", "start byte uses pointer", word, shadow[3]);

        // R8: high-speed code
        do_start(); send_byte(8'h0B, a0);
        chk(!a0, "R8", "hs code not acked", a0, 0);
        chk(hs == 1, "R8", "hs flag set", hs, 1);
        do_start(); send_byte({my_addr, 1'b0}, a1); send_byte(8'd2, a2);
        chk(a1 && a2 && hs == 1, "R8", "hs kept over repeated start", {a1, a2, hs}, 3'b111);
        do_stop();
        chk(hs == 0, "R8", "hs cleared by stop", hs, 0);

        // R11: repeated start mid-word
        w0 = wr_cnt;
        do_start(); send_byte({my_addr, 1'b0}, a0); send_byte(8'd1, a1); send_byte(8'hEE, a2);
        do_start(); send_byte({my_addr, 1'b1}, a3);
        recv_byte(1'b1, hb); recv_byte(1'b0, lb); do_stop();
        chk(wr_cnt == w0 && {hb, lb} == shadow[1], "R11", "abort keeps reg", {hb, lb}, shadow[1]);

        // R5: NACK after high byte
        s0 = stb_cnt;
        do_start(); send_byte({my_addr, 1'b1}, a0); recv_byte(1'b0, hb);
        a1 = 1;
        for (int k = 0; k < 9; k++) begin clk_bit(1'b1, a2); a1 &= a2; end
        do_stop();
        chk(hb == shadow[1][15:8] && a1 && stb_cnt - s0 == 1, "R5", "silent after nack",
            {hb, 7'(0), a1}, {shadow[1][15:8], 8'h01});

        // R9: SCL held low while slave drives a zero bit
        do_start(); send_byte({my_addr, 1'b1}, a0);
        repeat (100) @(negedge clk);
        chk(sda_oe == 1, "R9", "drive held before limit", sda_oe, 1);
        repeat (150) @(negedge clk);
        chk(sda_oe == 0, "R9", "released after timeout", sda_oe, 0);
        a1 = 1;
        for (int k = 0; k < 9; k++) begin clk_bit(1'b1, a2); a1 &= a2; end
        chk(a1, "R9", "bus ignored after timeout", a1, 1);
        do_stop();
        read_word({my_addr, 1'b1}, a0, word);
        chk(a0 && word == shadow[1], "R9", "new start works", word, shadow[1]);

        chk(unstable == 0, "R10", "SDA stable while SCL high", unstable, 0);
        finish_run();
    end
endmodule